// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block brings one switchable power partition, and the peripheral that lives inside it, from the off state to a running state. The steps always come in the same safe order. A one-cycle start pulse carries a partition number and a direction. For a power-up, the sequencer first holds the peripheral in reset. It then makes sure the partition is powered, enables the peripheral clock and waits. Next it releases the isolation clamp of that partition and waits again. Only then does it let the peripheral out of reset. A power-down request uses only the power step, with the target set to off.

The power step reads the partition's status bit first. When the partition is already in the target state, the request to the power switch is skipped. Otherwise a one-cycle toggle request goes to the switch, and the sequencer polls the status bit for a bounded time. If the status never matches, the sequence stops with a held error flag. The reset, clock and clamp are then left in their safe states.

All waits are counted in microsecond and millisecond ticks. A cycle prescaler produces these ticks, and it restarts at the entry to every step. Each wait therefore lasts a whole number of ticks and is never shorter than its nominal time.

Top module: `pwrseq_top`

## Requirements
- R1: A start accepted with `power_on_i`=1 sets `periph_rst_o` to 1 and `periph_clk_en_o` to 0 on the clock edge that accepts it. This happens before any toggle request.
- R2: If `pwr_status_i[part]` already equals the target state, no toggle request is issued and the sequence continues at once.
- R3: Otherwise `toggle_req_o` pulses for exactly one cycle, with `toggle_part_o` equal to the partition. The sequencer then waits until the status bit equals the target.
- R4: If the status does not match within TIMEOUT_MS milliseconds (TIMEOUT_MS*US_PER_MS*CYC_PER_US cycles) after the toggle, `err_o` rises, `busy_o` falls and `done_o` does not pulse.
- R5: After power is confirmed on, `periph_clk_en_o` rises while reset is still held. The clamp release follows no sooner than CLK_DELAY_US microseconds later.
- R6: `clamp_rel_o` is a single-cycle pulse, with bit number equal to the partition (one-hot). It occurs only while `periph_rst_o` and `periph_clk_en_o` are both 1.
- R7: `periph_rst_o` falls no sooner than CLAMP_DELAY_US microseconds after the clamp pulse. The one-cycle `done_o` pulse is in the same cycle.
- R8: A start with `power_on_i`=0 performs only the check, toggle and poll step towards off, with the same timeout. It leaves reset, clock enable and clamp untouched, then pulses `done_o`.
- R9: After a timeout, reset stays 1, the clock enable stays 0 and no clamp pulse appears. `err_o` is held until the next accepted start, which clears it.
- R10: A start while `busy_o` is 1 is ignored. `busy_o` stays 1 from the accepting edge until the `done_o` cycle or the error.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to run a sequence |
| power_on_i | input | 1 | Target state: 1 power-up sequence, 0 power-down |
| part_i | input | $clog2(NUM_PART) | Partition number |
| pwr_status_i | input | NUM_PART | Per-partition power-good status |
| periph_rst_o | output | 1 | Peripheral reset, active high |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| toggle_req_o | output | 1 | One-cycle power-switch toggle request |
| toggle_part_o | output | $clog2(NUM_PART) | Partition addressed by the toggle |
| clamp_rel_o | output | NUM_PART | One-hot clamp release pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Power-good timeout, held until next start |

## Verification
The hardest situation to reach from the ports is a partition whose switch never answers. Only in that case do the timeout window and the held safe state appear. The bench's power-switch model can mark a partition as dead, so that it ignores every toggle. The bench drives both a power-up and a power-down into such a partition and times the error against the toggle pulse. A second hard-to-reach case is a start that arrives in the middle of a long wait. It is injected during the power-good poll, and the event stream must stay exactly as it would be without that pulse.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_TOGGLE,
      ST_POLL,
      ST_CLK_WAIT,
      ST_UNCLAMP,
      ST_UNCLAMP_WAIT,
      ST_FINISH
   } seq_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwrseq_prescaler.sv
module pwrseq_prescaler #(
   parameter int unsigned CYC_PER_US = 125,
   parameter int unsigned US_PER_MS  = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic us_tick_o,
   output logic ms_tick_o
);

   localparam int unsigned UW = $clog2(US_PER_MS);
   localparam logic [UW-1:0] U_LAST = UW'(US_PER_MS - 1);

   generate
      if (CYC_PER_US == 1) begin : g_direct
         assign us_tick_o = !clr_i;
      end else begin : g_div
         localparam int unsigned CW = $clog2(CYC_PER_US);
         localparam logic [CW-1:0] C_LAST = CW'(CYC_PER_US - 1);
         logic [CW-1:0] cyc_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr_i || cyc_q == C_LAST) cyc_q <= '0;
            else                                   cyc_q <= cyc_q + 1'b1;
         end

         assign us_tick_o = !clr_i && (cyc_q == C_LAST);
      end
   endgenerate

   logic [UW-1:0] us_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i)  us_q <= '0;
      else if (us_tick_o)   us_q <= (us_q == U_LAST) ? '0 : us_q + 1'b1;
   end

   assign ms_tick_o = us_tick_o && (us_q == U_LAST);

endmodule

// File: rtl/pwrseq_tick_counter.sv
module pwrseq_tick_counter #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         tick_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i)                  cnt_q <= '0;
      else if (tick_i && cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q == limit_i);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
#(
   parameter int unsigned NUM_PART = 8,
   localparam int unsigned PW = $clog2(NUM_PART)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                power_on_i,
   input  logic [PW-1:0]       part_i,
   input  logic [NUM_PART-1:0] pwr_status_i,
   input  logic                us_expired_i,
   input  logic                ms_expired_i,
   output logic                timer_clr_o,
   output logic                clk_wait_o,
   output logic                periph_rst_o,
   output logic                periph_clk_en_o,
   output logic                toggle_req_o,
   output logic [PW-1:0]       toggle_part_o,
   output logic [NUM_PART-1:0] clamp_rel_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                err_o
);

   seq_state_e    state_q, state_d;
   logic [PW-1:0] part_q;
   logic          tgt_q;
   logic          rst_q, clken_q, err_q;
   logic          match;
   seq_state_e    after_power;

   assign match       = (pwr_status_i[part_q] == tgt_q);
   assign after_power = tgt_q ? ST_CLK_WAIT : ST_FINISH;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:         if (start_i) state_d = ST_CHECK;
         ST_CHECK:        state_d = match ? after_power : ST_TOGGLE;
         ST_TOGGLE:       state_d = ST_POLL;
         ST_POLL: begin
            if (match)             state_d = after_power;
            else if (ms_expired_i) state_d = ST_IDLE;
         end
         ST_CLK_WAIT:     if (us_expired_i) state_d = ST_UNCLAMP;
         ST_UNCLAMP:      state_d = ST_UNCLAMP_WAIT;
         ST_UNCLAMP_WAIT: if (us_expired_i) state_d = ST_FINISH;
         ST_FINISH:       state_d = ST_IDLE;
         default:         state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         part_q  <= '0;
         tgt_q   <= 1'b0;
         rst_q   <= 1'b0;
         clken_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            part_q <= part_i;
            tgt_q  <= power_on_i;
            err_q  <= 1'b0;
            if (power_on_i) begin
               rst_q   <= 1'b1;
               clken_q <= 1'b0;
            end
         end
         if (state_d == ST_CLK_WAIT && state_q != ST_CLK_WAIT) clken_q <= 1'b1;
         if (state_q == ST_UNCLAMP_WAIT && us_expired_i)       rst_q   <= 1'b0;
         if (state_q == ST_POLL && !match && ms_expired_i)     err_q   <= 1'b1;
      end
   end

   assign timer_clr_o     = (state_d != state_q);
   assign clk_wait_o      = (state_q == ST_CLK_WAIT);
   assign periph_rst_o    = rst_q;
   assign periph_clk_en_o = clken_q;
   assign toggle_req_o    = (state_q == ST_TOGGLE);
   assign toggle_part_o   = part_q;
   assign clamp_rel_o     = (state_q == ST_UNCLAMP) ? (NUM_PART'(1) << part_q) : '0;
   assign busy_o          = (state_q != ST_IDLE);
   assign done_o          = (state_q == ST_FINISH);
   assign err_o           = err_q;

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
   import pwrseq_pkg::*;
#(
   parameter int unsigned NUM_PART       = 8,
   parameter int unsigned CYC_PER_US     = 125,
   parameter int unsigned US_PER_MS      = 1000,
   parameter int unsigned TIMEOUT_MS     = 25,
   parameter int unsigned CLK_DELAY_US   = 10,
   parameter int unsigned CLAMP_DELAY_US = 10,
   localparam int unsigned PW = $clog2(NUM_PART)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                power_on_i,
   input  logic [PW-1:0]       part_i,
   input  logic [NUM_PART-1:0] pwr_status_i,
   output logic                periph_rst_o,
   output logic                periph_clk_en_o,
   output logic                toggle_req_o,
   output logic [PW-1:0]       toggle_part_o,
   output logic [NUM_PART-1:0] clamp_rel_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                err_o
);

   localparam int unsigned MSW = $clog2(TIMEOUT_MS + 1);
   localparam int unsigned USW = $clog2(max2(CLK_DELAY_US, CLAMP_DELAY_US) + 1);
   localparam logic [MSW-1:0] MS_LIMIT  = MSW'(TIMEOUT_MS);
   localparam logic [USW-1:0] CLK_LIM   = USW'(CLK_DELAY_US);
   localparam logic [USW-1:0] CLAMP_LIM = USW'(CLAMP_DELAY_US);

   initial begin
      assert (NUM_PART >= 2)      else $error("NUM_PART must be at least 2");
      assert (CYC_PER_US >= 1)    else $error("CYC_PER_US must be at least 1");
      assert (US_PER_MS >= 2)     else $error("US_PER_MS must be at least 2");
      assert (TIMEOUT_MS >= 1)    else $error("TIMEOUT_MS must be at least 1");
      assert (CLK_DELAY_US >= 1)  else $error("CLK_DELAY_US must be at least 1");
      assert (CLAMP_DELAY_US >= 1) else $error("CLAMP_DELAY_US must be at least 1");
   end

   logic timer_clr, clk_wait, us_tick, ms_tick, us_expired, ms_expired;
   logic [USW-1:0] us_limit;

   assign us_limit = clk_wait ? CLK_LIM : CLAMP_LIM;

   pwrseq_prescaler #(
      .CYC_PER_US (CYC_PER_US),
      .US_PER_MS  (US_PER_MS)
   ) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (timer_clr),
      .us_tick_o (us_tick),
      .ms_tick_o (ms_tick)
   );

   pwrseq_tick_counter #(.W(USW)) u_us_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (timer_clr),
      .tick_i    (us_tick),
      .limit_i   (us_limit),
      .expired_o (us_expired)
   );

   pwrseq_tick_counter #(.W(MSW)) u_ms_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (timer_clr),
      .tick_i    (ms_tick),
      .limit_i   (MS_LIMIT),
      .expired_o (ms_expired)
   );

   pwrseq_fsm #(.NUM_PART(NUM_PART)) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start_i),
      .power_on_i      (power_on_i),
      .part_i          (part_i),
      .pwr_status_i    (pwr_status_i),
      .us_expired_i    (us_expired),
      .ms_expired_i    (ms_expired),
      .timer_clr_o     (timer_clr),
      .clk_wait_o      (clk_wait),
      .periph_rst_o    (periph_rst_o),
      .periph_clk_en_o (periph_clk_en_o),
      .toggle_req_o    (toggle_req_o),
      .toggle_part_o   (toggle_part_o),
      .clamp_rel_o     (clamp_rel_o),
      .busy_o          (busy_o),
      .done_o          (done_o),
      .err_o           (err_o)
   );

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
   parameter int unsigned NUM_PART = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                periph_rst_o,
   input logic                periph_clk_en_o,
   input logic                toggle_req_o,
   input logic [NUM_PART-1:0] clamp_rel_o,
   input logic                busy_o,
   input logic                done_o,
   input logic                err_o
);

   AST_TOGGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      toggle_req_o |=> !toggle_req_o); // R3
   AST_TOGGLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      toggle_req_o |-> busy_o); // R3
   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (!busy_o && !done_o)); // R4
   AST_CLKEN_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_clk_en_o) |-> periph_rst_o); // R5
   AST_CLAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clamp_rel_o)); // R6
   AST_CLAMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (|clamp_rel_o) |-> (periph_rst_o && periph_clk_en_o)); // R6
   AST_CLAMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|clamp_rel_o) |=> (clamp_rel_o == '0)); // R6
   AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(periph_rst_o) |-> done_o); // R7
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> err_o); // R9
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> (busy_o || err_o)); // R10

endmodule

bind pwrseq_top pwrseq_checker #(.NUM_PART(NUM_PART)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_i         (start_i),
   .periph_rst_o    (periph_rst_o),
   .periph_clk_en_o (periph_clk_en_o),
   .toggle_req_o    (toggle_req_o),
   .clamp_rel_o     (clamp_rel_o),
   .busy_o          (busy_o),
   .done_o          (done_o),
   .err_o           (err_o)
);

// File: tb/tb_pwrseq_top.sv
module tb_pwrseq_top;

   localparam int NP   = 8;
   localparam int CPU  = 4;
   localparam int UPM  = 10;
   localparam int TOMS = 25;
   localparam int DUS  = 10;
   localparam int TO_CYC = TOMS * UPM * CPU;
   localparam int D_CYC  = DUS * CPU;

   localparam int EV_RST = 0, EV_TOG = 1, EV_CLK = 2, EV_CLAMP = 3, EV_DONE = 4, EV_ERR = 5;

   typedef struct {
      int    kind;
      int    part;
      int    gmin;
      int    gmax;
      bit    need_fall;
      string req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          power_on_i = 1'b0;
   logic [2:0]    part_i = '0;
   logic [NP-1:0] pwr_st;
   logic          periph_rst_o, periph_clk_en_o, toggle_req_o, busy_o, done_o, err_o;
   logic [2:0]    toggle_part_o;
   logic [NP-1:0] clamp_rel_o;

   int       cyc = 0;
   int       checks = 0;
   int       errors = 0;
   int       ref_cyc = 0;
   exp_t     expq[$];
   int       lat = 20;
   int       lat_cnt = 0;
   int       tpart = 0;
   bit [NP-1:0] dead = '0;
   logic [NP-1:0] preset_mask = '0;
   logic     preset_stb = 1'b0;
   logic     rst_prev = 1'b0, clk_prev = 1'b0, err_prev = 1'b0;

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   pwrseq_top #(
      .NUM_PART(NP), .CYC_PER_US(CPU), .US_PER_MS(UPM),
      .TIMEOUT_MS(TOMS), .CLK_DELAY_US(DUS), .CLAMP_DELAY_US(DUS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .power_on_i(power_on_i),
      .part_i(part_i), .pwr_status_i(pwr_st),
      .periph_rst_o(periph_rst_o), .periph_clk_en_o(periph_clk_en_o),
      .toggle_req_o(toggle_req_o), .toggle_part_o(toggle_part_o),
      .clamp_rel_o(clamp_rel_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   // power switch model
   always @(posedge clk) begin
      if (!rst_n) begin
         pwr_st  <= '0;
         lat_cnt <= 0;
      end else if (preset_stb) begin
         pwr_st <= pwr_st | preset_mask;
      end else if (toggle_req_o && !dead[toggle_part_o]) begin
         lat_cnt <= lat;
         tpart   <= int'(toggle_part_o);
      end else if (lat_cnt > 1) begin
         lat_cnt <= lat_cnt - 1;
      end else if (lat_cnt == 1) begin
         pwr_st[tpart] <= ~pwr_st[tpart];
         lat_cnt <= 0;
      end
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic push(input int kind, input int part, input int gmin, input int gmax,
                       input bit need_fall, input string req);
      exp_t e;
      e.kind = kind; e.part = part; e.gmin = gmin; e.gmax = gmax;
      e.need_fall = need_fall; e.req = req;
      expq.push_back(e);
   endtask

   // monitor: observe events at negedge and compare against the queue
   task automatic observe(input int kind, input int part, input bit fell);
      exp_t e;
      int   gap;
      gap = cyc - ref_cyc;
      if (expq.size() == 0) begin
         check(1'b0, "R10", "unexpected event kind", kind, -1);
      end else begin
         e = expq.pop_front();
         check(kind == e.kind, e.req, "event kind", kind, e.kind);
         if (kind == EV_TOG || kind == EV_CLAMP)
            check(part == e.part, e.req, "event partition", part, e.part);
         check(gap >= e.gmin && gap <= e.gmax, e.req, "event gap cycles", gap, e.gmin);
         if (e.need_fall)
            check(fell, e.req, "reset released with done", int'(fell), 1);
      end
      ref_cyc = cyc;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (periph_rst_o && !rst_prev)     observe(EV_RST, 0, 1'b0);
            if (toggle_req_o)                  observe(EV_TOG, int'(toggle_part_o), 1'b0);
            if (periph_clk_en_o && !clk_prev)  observe(EV_CLK, 0, 1'b0);
            if (|clamp_rel_o) begin
               int p = -1;
               for (int i = 0; i < NP; i++) if (clamp_rel_o[i]) p = i;
               check($countones(clamp_rel_o) == 1, "R6", "clamp one-hot count", $countones(clamp_rel_o), 1);
               observe(EV_CLAMP, p, 1'b0);
            end
            if (done_o)                        observe(EV_DONE, 0, rst_prev && !periph_rst_o);
            if (err_o && !err_prev)            observe(EV_ERR, 0, 1'b0);
         end
         rst_prev = periph_rst_o;
         clk_prev = periph_clk_en_o;
         err_prev = err_o;
      end
   end

   // driver
   task automatic start_op(input int part, input bit on);
      @(posedge clk); #1;
      start_i = 1'b1; part_i = 3'(part); power_on_i = on;
      ref_cyc = cyc;
      @(posedge clk); #1;
      start_i = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while ((expq.size() != 0 || busy_o) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check(expq.size() == 0, req, "pending expected events", expq.size(), 0);
      check(!busy_o, req, "busy after sequence", int'(busy_o), 0);
   endtask

   task automatic expect_powerup(input int part, input bit toggles, input string req_pwr);
      push(EV_RST, 0, 1, 1, 1'b0, "R1");
      if (toggles) begin
         push(EV_TOG, part, 1, 1, 1'b0, req_pwr);
         push(EV_CLK, 0, lat, lat + 3, 1'b0, "R5");
      end else begin
         push(EV_CLK, 0, 1, 2, 1'b0, "R2");
      end
      push(EV_CLAMP, part, D_CYC, D_CYC + 3, 1'b0, "R5");
      push(EV_DONE, 0, D_CYC, D_CYC + 4, 1'b1, "R7");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(!periph_rst_o && !periph_clk_en_o && !toggle_req_o, "R11", "control outputs in reset", 0, 0);
      check(clamp_rel_o == '0 && !busy_o && !done_o && !err_o, "R11", "status outputs in reset", 0, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(!busy_o && !err_o, "R11", "idle after reset", int'(busy_o), 0);

      // power-up of an off partition
      lat = 20;
      expect_powerup(2, 1'b1, "R3");
      start_op(2, 1'b1);
      @(negedge clk);
      check(periph_rst_o && !periph_clk_en_o, "R1", "reset before power", int'(periph_rst_o), 1);
      wait_idle("R3");
      check(periph_clk_en_o && !periph_rst_o, "R7", "running after power-up", int'(periph_rst_o), 0);

      // power-up of an already powered partition: no toggle
      @(posedge clk); #1; preset_mask = 8'h20; preset_stb = 1'b1;
      @(posedge clk); #1; preset_stb = 1'b0;
      expect_powerup(5, 1'b0, "R2");
      start_op(5, 1'b1);
      @(negedge clk);
      check(periph_rst_o && !periph_clk_en_o, "R1", "clock off under reset", int'(periph_clk_en_o), 0);
      wait_idle("R2");

      // power-up with an ignored start while polling
      lat = 30;
      expect_powerup(3, 1'b1, "R3");
      start_op(3, 1'b1);
      repeat (10) @(posedge clk);
      #1; start_i = 1'b1; part_i = 3'd4; power_on_i = 1'b1;
      @(posedge clk); #1; start_i = 1'b0;
      @(negedge clk);
      check(busy_o, "R10", "busy during sequence", int'(busy_o), 1);
      wait_idle("R10");
      check(pwr_st[4] == 1'b0, "R10", "ignored start left partition 4 off", int'(pwr_st[4]), 0);

      // power-down of a powered partition
      lat = 15;
      push(EV_TOG, 2, 2, 2, 1'b0, "R8");
      push(EV_DONE, 0, lat, lat + 3, 1'b0, "R8");
      start_op(2, 1'b0);
      wait_idle("R8");
      check(!periph_rst_o && periph_clk_en_o, "R8", "power-down left reset and clock", int'(periph_rst_o), 0);
      check(pwr_st[2] == 1'b0, "R8", "partition 2 off", int'(pwr_st[2]), 0);

      // power-down of an off partition: toggle skipped
      push(EV_DONE, 0, 2, 2, 1'b0, "R2");
      start_op(4, 1'b0);
      wait_idle("R2");

      // power-up of a dead partition: timeout
      dead = 8'h40;
      push(EV_RST, 0, 1, 1, 1'b0, "R1");
      push(EV_TOG, 6, 1, 1, 1'b0, "R3");
      push(EV_ERR, 0, TO_CYC, TO_CYC + 6, 1'b0, "R4");
      start_op(6, 1'b1);
      wait_idle("R4");
      repeat (50) @(negedge clk);
      check(err_o, "R9", "error held", int'(err_o), 1);
      check(periph_rst_o && !periph_clk_en_o, "R9", "safe state after timeout", int'(periph_clk_en_o), 0);

      // power-down of a dead powered partition: timeout, error cleared by start
      @(posedge clk); #1; preset_mask = 8'h80; preset_stb = 1'b1;
      @(posedge clk); #1; preset_stb = 1'b0;
      dead = 8'hC0;
      push(EV_TOG, 7, 2, 2, 1'b0, "R8");
      push(EV_ERR, 0, TO_CYC, TO_CYC + 6, 1'b0, "R4");
      start_op(7, 1'b0);
      @(negedge clk);
      check(!err_o, "R9", "error cleared by start", int'(err_o), 0);
      wait_idle("R8");
      check(err_o, "R4", "power-down timeout flagged", int'(err_o), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cyc >= 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule